// File: doc/BRIEF.md
# Slot-Wheel Injection Scheduler for a Network Interface

This block decides which connection of a network interface may put a flit onto the network link. Every flit slot lasts three cycles. A small programmable reservation wheel names the connection that owns each slot. A guaranteed connection sends only in the slots it owns. A best-effort connection takes any slot that has no owner, and any slot whose owner has nothing it can send. When several best-effort connections can send, the next one after the last served is picked in round-robin order.

Each connection has its own request queue. The attached IP writes into the queue through one shared write port and is stalled when that connection's queue is full. A connection can send only while it holds at least one queued word and at least one end-to-end credit. Credits come back as counts on a return port, piggy-backed on traffic in the reverse direction. Each granted slot carries one packet:
- the first cycle is a header word holding the connection's source route;
- up to two data words follow;
- any cycle left over is idle, which keeps packets aligned to the three-word flit.

The wheel, the routes, the connection classes and the wheel length are written through a small configuration port. This is normally done once per operating mode. The number of connections, the wheel size and the queue depth must be powers of two.

Top module: `tdma_ni_sched`

## Requirements
- R1: After reset `out_valid` is 0, every queue is empty so `in_ready` is 1 for any `in_conn`, every wheel entry is unreserved, and all credit counts are zero.
- R2: A flit slot is three cycles. A granted packet shows `out_head`=1 with `out_valid`=1 only in the first cycle of a slot. Its data words follow in the next one or two cycles, carrying the same `out_conn`, and `out_last` marks the final data word. Cycles of the slot that carry no word have `out_valid`=0.
- R3: The wheel pointer starts at entry 0. It moves on by one entry per slot and returns to 0 after the entry whose index was written at configuration address SLOTS+NCONN (bits SW-1:0). That index is SLOTS-1 after reset.
- R4: A wheel entry at address a<SLOTS holds `cfg_data[CW]`=reserved and `cfg_data[CW-1:0]`=owner. In a reserved slot an owner that can send is granted. A guaranteed connection (class bit `cfg_data[DW]`=1 at its route address) is granted only in slots it owns.
- R5: A slot with no owner, or with an owner that cannot send, goes to a best-effort connection that can send. The first such connection after the one served last (in cyclic index order, starting from connection 0 after reset) is chosen.
- R6: A connection can send only if its queue holds at least one word and its credit count is at least one; otherwise it receives no packet.
- R7: A packet carries min(queued words, credits, 2) data words. The credit count drops by exactly that number. A pulse on `cr_valid` adds `cr_amount` to the credits of `cr_conn`.
- R8: The header word equals the route written at configuration address SLOTS+c (bits DW-1:0) for the granted connection c.
- R9: Each queue delivers words in write order. `in_ready` is 0 while the queue selected by `in_conn` holds FDEPTH words, and a write offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration address: wheel entries, then routes, then wheel last index |
| cfg_data | input | DW+1 | Configuration write data |
| in_valid | input | 1 | IP offers a word |
| in_conn | input | CW | Connection the offered word belongs to |
| in_data | input | DW | Offered word |
| in_ready | output | 1 | Queue of `in_conn` has room |
| cr_valid | input | 1 | Credit return strobe |
| cr_conn | input | CW | Connection receiving credits |
| cr_amount | input | CRW | Number of credits returned |
| out_valid | output | 1 | A word is on the link this cycle |
| out_head | output | 1 | The word is a packet header |
| out_last | output | 1 | The word is the last data word of the packet |
| out_conn | output | CW | Connection that owns the word |
| out_word | output | DW | Header or data word |

## Verification
The assertions take the following for granted:
- the IP writes only while `in_ready` is high;
- returned credits never carry a count past its width;
- the wheel length and the entries are not rewritten while traffic is in flight.

The bench keeps within these limits in four ways. It writes the whole configuration before any queue holds data. It returns only as many credits as the data it will send. It reads `in_ready` before filling a queue to its depth. It counts wheel slots from the release of reset, so it can predict which entry each slot falls on.

// File: rtl/tdma_ni_sched.sv
module tdma_ni_sched #(
  parameter int NCONN = 4,
  parameter int SLOTS = 8,
  parameter int FDEPTH = 4,
  parameter int DW = 8,
  parameter int CRW = 4,
  localparam int CW = $clog2(NCONN),
  localparam int SW = $clog2(SLOTS),
  localparam int AW = $clog2(SLOTS + NCONN + 1),
  localparam int FW = $clog2(FDEPTH),
  localparam int NW = $clog2(FDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW:0]   cfg_data,
  input  logic          in_valid,
  input  logic [CW-1:0] in_conn,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          cr_valid,
  input  logic [CW-1:0] cr_conn,
  input  logic [CRW-1:0] cr_amount,
  output logic          out_valid,
  output logic          out_head,
  output logic          out_last,
  output logic [CW-1:0] out_conn,
  output logic [DW-1:0] out_word
);

  logic [SLOTS-1:0][CW:0]   tbl;
  logic [SW-1:0]            last_idx, sp;
  logic [1:0]               ph;
  logic [NCONN-1:0]         gt;
  logic [NCONN-1:0][DW-1:0] route;
  logic [NCONN-1:0][CRW-1:0] cred;
  logic [NCONN-1:0][NW-1:0] cnt;
  logic [NCONN-1:0][FW-1:0] rp, wp;
  logic [DW-1:0]            mem [NCONN][FDEPTH];
  logic [CW-1:0]            rr, cur_c;
  logic [1:0]               cur_n;

  logic [NCONN-1:0] elig;
  logic             own_ok, be_hit, grant, push_en, pop_en;
  logic [CW-1:0]    own, be_c, g, idx;
  logic [1:0]       ng;

  assign own = tbl[sp][CW-1:0];

  always_comb begin
    for (int c = 0; c < NCONN; c++)
      elig[c] = (cnt[c] != '0) && (cred[c] != '0);
    own_ok = tbl[sp][CW] && elig[own];
    be_hit = 1'b0;
    be_c   = rr;
    idx    = rr;
    for (int k = NCONN; k >= 1; k--) begin
      idx = rr + CW'(k);
      if (elig[idx] && !gt[idx]) begin
        be_hit = 1'b1;
        be_c   = idx;
      end
    end
  end

  assign grant = (ph == 2'd0) && (own_ok || be_hit);
  assign g     = own_ok ? own : be_c;

  always_comb begin
    ng = 2'd2;
    if (cnt[g] < NW'(2)) ng = 2'(cnt[g]);
    if (cred[g] < CRW'(ng)) ng = 2'(cred[g]);
  end

  assign in_ready = cnt[in_conn] != NW'(FDEPTH);
  assign push_en  = in_valid && in_ready;
  assign pop_en   = (ph == 2'd1 && cur_n != 2'd0) || (ph == 2'd2 && cur_n == 2'd2);

  assign out_head  = grant;
  assign out_valid = grant || pop_en;
  assign out_last  = (ph == 2'd1 && cur_n == 2'd1) || (ph == 2'd2 && cur_n == 2'd2);
  assign out_conn  = grant ? g : cur_c;
  assign out_word  = grant ? route[g] : mem[cur_c][rp[cur_c]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl      <= '0;
      last_idx <= SW'(SLOTS - 1);
      sp       <= '0;
      ph       <= '0;
      gt       <= '0;
      route    <= '0;
      cred     <= '0;
      cnt      <= '0;
      rp       <= '0;
      wp       <= '0;
      rr       <= CW'(NCONN - 1);
      cur_c    <= '0;
      cur_n    <= '0;
    end else begin
      ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      if (ph == 2'd2) sp <= (sp >= last_idx) ? '0 : sp + SW'(1);
      if (ph == 2'd0) begin
        cur_n <= grant ? ng : 2'd0;
        cur_c <= g;
        if (grant && !own_ok) rr <= be_c;
      end
      if (cfg_we) begin
        if (cfg_addr < AW'(SLOTS)) tbl[cfg_addr[SW-1:0]] <= cfg_data[CW:0];
        if (cfg_addr == AW'(SLOTS + NCONN)) last_idx <= cfg_data[SW-1:0];
        for (int c = 0; c < NCONN; c++)
          if (cfg_addr == AW'(SLOTS + c)) begin
            route[c] <= cfg_data[DW-1:0];
            gt[c]    <= cfg_data[DW];
          end
      end
      for (int c = 0; c < NCONN; c++) begin
        cred[c] <= cred[c]
                 + ((cr_valid && cr_conn == CW'(c)) ? cr_amount : '0)
                 - ((grant && g == CW'(c)) ? CRW'(ng) : '0);
        cnt[c]  <= cnt[c] + NW'(push_en && in_conn == CW'(c))
                          - NW'(pop_en && cur_c == CW'(c));
        if (push_en && in_conn == CW'(c)) wp[c] <= wp[c] + FW'(1);
        if (pop_en && cur_c == CW'(c))    rp[c] <= rp[c] + FW'(1);
      end
    end
  end

  always_ff @(posedge clk)
    if (push_en) mem[in_conn][wp[in_conn]] <= in_data;

endmodule

// File: rtl/tdma_ni_sched_chk.sv
module tdma_ni_sched_chk #(
  parameter int NCONN = 4,
  parameter int SLOTS = 8,
  localparam int CW = $clog2(NCONN),
  localparam int SW = $clog2(SLOTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            ph,
  input logic [SW-1:0]         sp,
  input logic [SW-1:0]         last_idx,
  input logic [SLOTS-1:0][CW:0] tbl,
  input logic [NCONN-1:0]      gt,
  input logic                  out_valid,
  input logic                  out_head,
  input logic                  out_last,
  input logic [CW-1:0]         out_conn
);

  p_head_phase0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_head |-> out_valid && ph == 2'd0);

  p_data_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_head |=> out_valid && !out_head && out_conn == $past(out_conn));

  p_last_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid || out_head);

  p_gt_own_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_head && gt[out_conn]) |-> tbl[sp][CW] && tbl[sp][CW-1:0] == out_conn);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && sp >= last_idx) |=> sp == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && sp < last_idx) |=> sp == $past(sp) + SW'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd2) |=> $stable(sp));

endmodule

bind tdma_ni_sched tdma_ni_sched_chk #(.NCONN(NCONN), .SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ph(ph), .sp(sp), .last_idx(last_idx), .tbl(tbl),
  .gt(gt), .out_valid(out_valid), .out_head(out_head), .out_last(out_last),
  .out_conn(out_conn)
);

// File: tb/tdma_ni_sched_tb_top.sv
module tdma_ni_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, cfg_we, in_valid, in_ready, cr_valid;
  logic       out_valid, out_head, out_last;
  logic [3:0] cfg_addr;
  logic [8:0] cfg_data;
  logic [1:0] in_conn, cr_conn, out_conn;
  logic [7:0] in_data, out_word;
  logic [3:0] cr_amount;

  tdma_ni_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_conn(in_conn), .in_data(in_data), .in_ready(in_ready),
    .cr_valid(cr_valid), .cr_conn(cr_conn), .cr_amount(cr_amount),
    .out_valid(out_valid), .out_head(out_head), .out_last(out_last),
    .out_conn(out_conn), .out_word(out_word)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, npk = 0;
  int pk_conn [32], pk_slot [32], pk_n [32], pk_hw [32], pk_w0 [32], pk_w1 [32];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (out_head) begin
        check(cyc % 3 == 0, "R2 header in first slot cycle", cyc % 3, 0);
        pk_conn[npk] = int'(out_conn);
        pk_slot[npk] = cyc / 3;
        pk_hw[npk]   = int'(out_word);
        pk_n[npk]    = 0;
      end else begin
        if (pk_n[npk] == 0) pk_w0[npk] = int'(out_word);
        else                pk_w1[npk] = int'(out_word);
        pk_n[npk] = pk_n[npk] + 1;
        if (out_last) npk = npk + 1;
      end
    end
  end

  task automatic cfg(input logic [3:0] a, input logic [8:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [1:0] c, input logic [7:0] d);
    in_valid = 1'b1; in_conn = c; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic credit(input logic [1:0] c, input logic [3:0] a);
    cr_valid = 1'b1; cr_conn = c; cr_amount = a;
    @(negedge clk);
    cr_valid = 1'b0;
  endtask

  task automatic wait_pkts(input int target, input string req);
    int guard = 0;
    while (npk < target && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    check(npk >= target, req, npk, target);
  endtask

  task automatic chk_pkt(input int i, input int c, input int n, input int w0, input int w1,
                         input string req);
    check(pk_conn[i] == c, req, pk_conn[i], c);
    check(pk_hw[i] == 8'h50 + c, "R8 header carries route", pk_hw[i], 8'h50 + c);
    check(pk_n[i] == n, req, pk_n[i], n);
    check(pk_w0[i] == w0, "R9 word order", pk_w0[i], w0);
    if (n == 2) check(pk_w1[i] == w1, "R9 word order", pk_w1[i], w1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    in_valid = 1'b0; in_conn = '0; in_data = '0;
    cr_valid = 1'b0; cr_conn = '0; cr_amount = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 no output in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 queues empty", int'(in_ready), 1);

    // wheel of four entries: written together with reset release
    cfg_we = 1'b1; cfg_addr = 4'd12; cfg_data = 9'd3; rst_n = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
    cfg(4'd0, 9'h004);
    cfg(4'd2, 9'h005);
    cfg(4'd8, 9'h150);
    cfg(4'd9, 9'h151);
    cfg(4'd10, 9'h052);
    cfg(4'd11, 9'h053);
    repeat (6) @(negedge clk);
    check(npk == 0, "R6 no credits no packets", npk, 0);

    // R4: guaranteed connection 0 in slots 0 mod 4
    push(2'd0, 8'h10); push(2'd0, 8'h11);
    credit(2'd0, 4'd2);
    wait_pkts(1, "R4 packet for owner");
    chk_pkt(0, 0, 2, 8'h10, 8'h11, "R4 owner packet");
    check(pk_slot[0] % 4 == 0, "R3 R4 owner slot position", pk_slot[0] % 4, 0);

    // R7: credit cap of one word, then hold, then refill
    push(2'd1, 8'h20); push(2'd1, 8'h21); push(2'd1, 8'h22);
    credit(2'd1, 4'd1);
    wait_pkts(2, "R7 capped packet");
    chk_pkt(1, 1, 1, 8'h20, 0, "R7 one credit one word");
    check(pk_slot[1] % 4 == 2, "R3 R4 slot of connection 1", pk_slot[1] % 4, 2);
    repeat (24) @(negedge clk);
    check(npk == 2, "R6 R7 credits used up", npk, 2);
    credit(2'd1, 4'd4);
    wait_pkts(3, "R7 refill");
    chk_pkt(2, 1, 2, 8'h21, 8'h22, "R7 two words per packet");
    check(pk_slot[2] % 4 == 2, "R4 slot of connection 1", pk_slot[2] % 4, 2);

    // R5: best effort fills every slot, round robin
    push(2'd2, 8'h30); push(2'd2, 8'h31); push(2'd2, 8'h32); push(2'd2, 8'h33);
    push(2'd3, 8'h40); push(2'd3, 8'h41); push(2'd3, 8'h42); push(2'd3, 8'h43);
    credit(2'd2, 4'd4);
    credit(2'd3, 4'd4);
    wait_pkts(7, "R5 best-effort packets");
    chk_pkt(3, 2, 2, 8'h30, 8'h31, "R5 round robin first");
    chk_pkt(4, 3, 2, 8'h40, 8'h41, "R5 round robin second");
    chk_pkt(5, 2, 2, 8'h32, 8'h33, "R5 round robin third");
    chk_pkt(6, 3, 2, 8'h42, 8'h43, "R5 round robin fourth");
    for (int i = 3; i < 6; i++)
      check(pk_slot[i + 1] == pk_slot[i] + 1, "R5 idle-owner slots reused",
            pk_slot[i + 1] - pk_slot[i], 1);

    // R4 and R5 mixed
    push(2'd2, 8'h34); push(2'd2, 8'h35); push(2'd2, 8'h36); push(2'd2, 8'h37);
    push(2'd0, 8'h12);
    credit(2'd0, 4'd1);
    credit(2'd2, 4'd4);
    wait_pkts(10, "R4 R5 mixed packets");
    begin
      int n0 = 0, nb = 0;
      for (int i = 7; i < 10; i++) begin
        if (pk_conn[i] == 0) begin
          n0++;
          check(pk_slot[i] % 4 == 0, "R4 guaranteed only in own slot", pk_slot[i] % 4, 0);
          check(pk_n[i] == 1 && pk_w0[i] == 8'h12, "R7 single word", pk_w0[i], 8'h12);
        end else begin
          check(pk_conn[i] == 2, "R5 best-effort connection", pk_conn[i], 2);
          check(pk_w0[i] == 8'h34 + 2 * nb, "R9 word order", pk_w0[i], 8'h34 + 2 * nb);
          nb++;
        end
      end
      check(n0 == 1, "R4 one owner packet", n0, 1);
    end

    // R9 stall, R6 no credit
    push(2'd3, 8'h44); push(2'd3, 8'h45); push(2'd3, 8'h46); push(2'd3, 8'h47);
    in_conn = 2'd3; #1;
    check(in_ready == 1'b0, "R9 full queue stalls", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    in_conn = 2'd2; #1;
    check(in_ready == 1'b1, "R9 other queue ready", int'(in_ready), 1);
    repeat (18) @(negedge clk);
    check(npk == 10, "R6 words without credit wait", npk, 10);
    credit(2'd3, 4'd3);
    wait_pkts(12, "R7 credits resume");
    chk_pkt(10, 3, 2, 8'h44, 8'h45, "R7 first of three credits");
    chk_pkt(11, 3, 1, 8'h46, 0, "R7 last credit one word");
    repeat (18) @(negedge clk);
    check(npk == 12, "R7 credits spent per word", npk, 12);
    in_conn = 2'd3; #1;
    check(in_ready == 1'b1, "R9 room after drain", int'(in_ready), 1);
    credit(2'd3, 4'd1);
    wait_pkts(13, "R9 rejected write not stored");
    chk_pkt(12, 3, 1, 8'h47, 0, "R9 full-queue write dropped");
    repeat (18) @(negedge clk);
    check(npk == 13, "R9 no extra word", npk, 13);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule